// File: doc/BRIEF.md
# Destination ID Acceptance Filter

This block sits at the receive side of a packet endpoint and decides, one packet at a time, whether an arriving packet belongs to this endpoint. When a packet starts, the header's destination ID is presented with a one-cycle start strobe. The filter compares that ID against a programmable local device ID. If multicast is enabled, it also compares the ID against a programmable multicast device ID. One clock later it raises either an accept pulse or a drop pulse.

Software programs the two ID registers, a mode register and a drop counter over a simple single-cycle register bus. The mode register holds two bits. One enables multicast acceptance. The other narrows every comparison to the low 8 bits, for systems that use short device IDs. Dropped packets are tallied in a saturating counter that software clears by writing to it.

Top module: `devid_accept_filter`

## Requirements
- R1: After reset, the local ID, multicast ID, mode and drop-count registers all read 0, and both `pkt_accept` and `pkt_drop` are low.
- R2: When mode bit 5 is 0, a packet is accepted if and only if its destination ID equals the local device ID register. In the default 16-bit size, all 16 bits are compared.
- R3: When mode bit 5 is 1, a packet is accepted if its destination ID equals either the local device ID register or the multicast device ID register. Otherwise it is dropped.
- R4: When mode bit 5 is 0, an ID that matches only the multicast device ID register is dropped.
- R5: When mode bit 0 is 1, only bits [7:0] of the destination ID and of both ID registers take part in the comparison. Bits [15:8] of all three are ignored.
- R6: For each cycle in which `pkt_start` is high, exactly one of `pkt_accept` or `pkt_drop` is high in the following cycle. Neither output is ever high in a cycle that does not follow a strobe.
- R7: Bus reads return the local ID at offset 0x080 and the multicast ID at 0x084. The mode register is at 0x088, with multicast enable at bit 5 and 8-bit size at bit 0. The drop count is at 0x08C. Mode bits other than 5 and 0 read as 0.
- R8: The drop counter (`drop_count`, also readable at 0x08C) increases by one for each dropped packet. It holds at 0xFFFF once it reaches that value.
- R9: Any write to offset 0x08C clears the drop counter. A drop decided in the same cycle as that write is counted after the clear, so the counter then reads 1.
- R10: A register write issued in the same cycle as `pkt_start` does not affect that packet's decision. The packet is judged against the values held before the write, and the new value governs the packets that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | One-cycle strobe marking the start of a packet |
| pkt_dest_id | input | 16 | Destination ID from the packet header, valid with `pkt_start` |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 12 | Register byte offset for reads and writes |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` (combinational) |
| pkt_accept | output | 1 | Pulse one cycle after the strobe when the packet is accepted |
| pkt_drop | output | 1 | Pulse one cycle after the strobe when the packet is discarded |
| drop_count | output | 16 | Saturating dropped-packet count |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a packet decision and a register write. The bench issues a write that changes the local ID on the same clock edge as a strobe carrying the old ID, and expects an accept; a second packet then confirms that the new ID governs. The second pair is a counter clear and a drop decision. The bench lands both on the same edge and expects a count of exactly 1. Separately, unbroken back-to-back strobes push the counter past 65535 drops to confirm that it holds at 0xFFFF.

// File: rtl/devid_pkg.sv
package devid_pkg;

   // Default register byte offsets
   localparam logic [11:0] OFS_LOCAL_ID = 12'h080;
   localparam logic [11:0] OFS_MCAST_ID = 12'h084;
   localparam logic [11:0] OFS_MODE     = 12'h088;
   localparam logic [11:0] OFS_DROP_CNT = 12'h08C;

   // Default positions of the mode bits
   localparam int MODE_MC_BIT   = 5;
   localparam int MODE_SIZE_BIT = 0;

   typedef struct packed {
      logic mc_en;     // multicast ID also accepted
      logic narrow;    // compare low bits only
   } mode_t;

endpackage

// File: rtl/devid_regs.sv
module devid_regs
   import devid_pkg::*;
#(
   parameter int          ID_W      = 16,
   parameter int          CNT_W     = 16,
   parameter int          ADDR_W    = 12,
   parameter int          DATA_W    = 16,
   parameter logic [11:0] LOCAL_OFS = OFS_LOCAL_ID,
   parameter logic [11:0] MCAST_OFS = OFS_MCAST_ID,
   parameter logic [11:0] MODE_OFS  = OFS_MODE,
   parameter logic [11:0] CNT_OFS   = OFS_DROP_CNT,
   parameter int          MC_BIT    = MODE_MC_BIT,
   parameter int          SIZE_BIT  = MODE_SIZE_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  cnt_val,
   output logic [ID_W-1:0]   local_id,
   output logic [ID_W-1:0]   mcast_id,
   output mode_t             mode,
   output logic              cnt_clr
);

   localparam logic [ADDR_W-1:0] A_LOCAL = ADDR_W'(LOCAL_OFS);
   localparam logic [ADDR_W-1:0] A_MCAST = ADDR_W'(MCAST_OFS);
   localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(MODE_OFS);
   localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(CNT_OFS);

   generate
      if (ID_W > DATA_W) begin : g_bad_idw
         $error("devid_regs: ID_W must not exceed DATA_W");
      end
      if (CNT_W > DATA_W) begin : g_bad_cntw
         $error("devid_regs: CNT_W must not exceed DATA_W");
      end
      if (MC_BIT >= DATA_W || SIZE_BIT >= DATA_W || MC_BIT == SIZE_BIT) begin : g_bad_bits
         $error("devid_regs: mode bit positions invalid");
      end
   endgenerate

   assign cnt_clr = bus_wr && (bus_addr == A_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         local_id <= '0;
         mcast_id <= '0;
         mode     <= '0;
      end else if (bus_wr) begin
         if (bus_addr == A_LOCAL) local_id <= bus_wdata[ID_W-1:0];
         if (bus_addr == A_MCAST) mcast_id <= bus_wdata[ID_W-1:0];
         if (bus_addr == A_MODE) begin
            mode.mc_en  <= bus_wdata[MC_BIT];
            mode.narrow <= bus_wdata[SIZE_BIT];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_LOCAL)      bus_rdata[ID_W-1:0]  = local_id;
      else if (bus_addr == A_MCAST) bus_rdata[ID_W-1:0]  = mcast_id;
      else if (bus_addr == A_MODE) begin
         bus_rdata[MC_BIT]   = mode.mc_en;
         bus_rdata[SIZE_BIT] = mode.narrow;
      end
      else if (bus_addr == A_CNT)   bus_rdata[CNT_W-1:0] = cnt_val;
   end

endmodule

// File: rtl/devid_match.sv
module devid_match
   import devid_pkg::*;
#(
   parameter int ID_W    = 16,
   parameter int SMALL_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pkt_start,
   input  logic [ID_W-1:0] pkt_dest_id,
   input  logic [ID_W-1:0] local_id,
   input  logic [ID_W-1:0] mcast_id,
   input  mode_t           mode,
   output logic            drop_now,
   output logic            accept_q,
   output logic            drop_q
);

   logic [ID_W-1:0] cmp_mask;
   logic            hit_local;
   logic            hit_mcast;
   logic            accept_now;

   generate
      if (SMALL_W < 1 || SMALL_W > ID_W) begin : g_bad_small
         $error("devid_match: SMALL_W must lie in 1..ID_W");
      end
      if (SMALL_W < ID_W) begin : g_narrow
         localparam logic [ID_W-1:0] NARROW_MASK =
            {{(ID_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};
         assign cmp_mask = mode.narrow ? NARROW_MASK : {ID_W{1'b1}};
      end else begin : g_full
         // Narrow size equals full size: the size bit leaves the mask unchanged.
         assign cmp_mask = {ID_W{1'b1}} | {ID_W{mode.narrow}};
      end
   endgenerate

   always_comb begin
      hit_local  = ((pkt_dest_id ^ local_id) & cmp_mask) == '0;
      hit_mcast  = mode.mc_en && (((pkt_dest_id ^ mcast_id) & cmp_mask) == '0);
      accept_now = pkt_start && (hit_local || hit_mcast);
      drop_now   = pkt_start && !(hit_local || hit_mcast);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         accept_q <= 1'b0;
         drop_q   <= 1'b0;
      end else begin
         accept_q <= accept_now;
         drop_q   <= drop_now;
      end
   end

endmodule

// File: rtl/devid_sat_counter.sv
module devid_sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);

   logic [W-1:0] base;
   logic         step;

   generate
      if (W < 1) begin : g_bad_w
         $error("devid_sat_counter: W must be positive");
      end
   endgenerate

   always_comb begin
      base = clr ? '0 : q;
      step = inc && (base != {W{1'b1}});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= base + W'(step);
   end

endmodule

// File: rtl/devid_accept_filter.sv
module devid_accept_filter
   import devid_pkg::*;
#(
   parameter int          ID_W      = 16,
   parameter int          SMALL_W   = 8,
   parameter int          CNT_W     = 16,
   parameter int          ADDR_W    = 12,
   parameter int          DATA_W    = 16,
   parameter logic [11:0] LOCAL_OFS = OFS_LOCAL_ID,
   parameter logic [11:0] MCAST_OFS = OFS_MCAST_ID,
   parameter logic [11:0] MODE_OFS  = OFS_MODE,
   parameter logic [11:0] CNT_OFS   = OFS_DROP_CNT,
   parameter int          MC_BIT    = MODE_MC_BIT,
   parameter int          SIZE_BIT  = MODE_SIZE_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_start,
   input  logic [ID_W-1:0]   pkt_dest_id,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pkt_accept,
   output logic              pkt_drop,
   output logic [CNT_W-1:0]  drop_count
);

   generate
      if (ADDR_W > 12) begin : g_bad_addr
         $error("devid_accept_filter: ADDR_W limited to 12");
      end
   endgenerate

   logic [ID_W-1:0] local_id;
   logic [ID_W-1:0] mcast_id;
   mode_t           mode;
   logic            cnt_clr;
   logic            drop_now;

   devid_regs #(
      .ID_W(ID_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .LOCAL_OFS(LOCAL_OFS), .MCAST_OFS(MCAST_OFS),
      .MODE_OFS(MODE_OFS), .CNT_OFS(CNT_OFS),
      .MC_BIT(MC_BIT), .SIZE_BIT(SIZE_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt_val(drop_count),
      .local_id(local_id), .mcast_id(mcast_id),
      .mode(mode), .cnt_clr(cnt_clr)
   );

   devid_match #(
      .ID_W(ID_W), .SMALL_W(SMALL_W)
   ) u_match (
      .clk(clk), .rst_n(rst_n),
      .pkt_start(pkt_start), .pkt_dest_id(pkt_dest_id),
      .local_id(local_id), .mcast_id(mcast_id), .mode(mode),
      .drop_now(drop_now),
      .accept_q(pkt_accept), .drop_q(pkt_drop)
   );

   devid_sat_counter #(
      .W(CNT_W)
   ) u_drop_cnt (
      .clk(clk), .rst_n(rst_n),
      .clr(cnt_clr), .inc(drop_now),
      .q(drop_count)
   );

endmodule

// File: rtl/devid_accept_filter_chk.sv
module devid_accept_filter_chk #(
   parameter int          CNT_W   = 16,
   parameter int          ADDR_W  = 12,
   parameter logic [11:0] CNT_OFS = 12'h08C
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pkt_start,
   input logic              pkt_accept,
   input logic              pkt_drop,
   input logic [CNT_W-1:0]  drop_count,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr
);

   logic clr_wr;
   assign clr_wr = bus_wr && (bus_addr == ADDR_W'(CNT_OFS));

   // R6: never both outcomes at once
   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pkt_accept && pkt_drop));

   // R6: every strobe yields one outcome on the next cycle
   a_r6_outcome_follows: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_start |=> (pkt_accept || pkt_drop));

   // R6: no outcome without a strobe
   a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_start |=> (!pkt_accept && !pkt_drop));

   // R8, R9: a drop moves the count up by one unless saturated or cleared
   a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_drop |-> (drop_count == $past(drop_count) + CNT_W'(1)
                    || $past(drop_count) == {CNT_W{1'b1}}
                    || $past(clr_wr)));

   // R8: without a drop or clear the count holds
   a_r8_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!pkt_drop && !$past(clr_wr)) |-> $stable(drop_count));

   // R9: a clear leaves the count at 0 or 1
   a_r9_clear_result: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_wr) |-> (drop_count <= CNT_W'(1)));

endmodule

bind devid_accept_filter devid_accept_filter_chk #(
   .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CNT_OFS(CNT_OFS)
) u_chk (.*);

// File: tb/tb_devid_accept_filter.sv
module tb_devid_accept_filter;

   localparam logic [11:0] A_LOC  = 12'h080;
   localparam logic [11:0] A_MC   = 12'h084;
   localparam logic [11:0] A_MODE = 12'h088;
   localparam logic [11:0] A_CNT  = 12'h08C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pkt_start = 1'b0;
   logic [15:0] pkt_dest_id = '0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        pkt_accept;
   logic        pkt_drop;
   logic [15:0] drop_count;

   int checks = 0;
   int errors = 0;

   // bench model of the programmed state
   logic [15:0] m_loc = '0;
   logic [15:0] m_mc = '0;
   logic        m_mcen = 1'b0;
   logic        m_narrow = 1'b0;
   logic [15:0] exp_cnt = '0;

   always #5 clk = ~clk;

   devid_accept_filter dut (
      .clk(clk), .rst_n(rst_n),
      .pkt_start(pkt_start), .pkt_dest_id(pkt_dest_id),
      .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pkt_accept(pkt_accept), .pkt_drop(pkt_drop),
      .drop_count(drop_count)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit model_accept(input logic [15:0] id);
      logic [15:0] mk;
      mk = m_narrow ? 16'h00FF : 16'hFFFF;
      return (((id ^ m_loc) & mk) == 0) ||
             (m_mcen && (((id ^ m_mc) & mk) == 0));
   endfunction

   task automatic wr(input logic [11:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == A_LOC)  m_loc = d;
      if (a == A_MC)   m_mc = d;
      if (a == A_MODE) begin m_mcen = d[5]; m_narrow = d[0]; end
      if (a == A_CNT)  exp_cnt = '0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [15:0] e, input string req);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(bus_rdata === e, req, "readback", int'(bus_rdata), int'(e));
   endtask

   task automatic send(input logic [15:0] id, input string req);
      bit e;
      e = model_accept(id);
      @(negedge clk);
      pkt_start = 1'b1; pkt_dest_id = id;
      @(negedge clk);
      pkt_start = 1'b0;
      chk(pkt_accept === e && pkt_drop === !e, req, "decision",
          int'({pkt_accept, pkt_drop}), int'({e, !e}));
      if (!e && exp_cnt != 16'hFFFF) exp_cnt++;
   endtask

   task automatic cnt_chk(input string req);
      chk(drop_count === exp_cnt, req, "drop_count", int'(drop_count), int'(exp_cnt));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk(pkt_accept === 1'b0 && pkt_drop === 1'b0, "R1", "pulses", int'({pkt_accept, pkt_drop}), 0);
      rd_chk(A_LOC, 16'h0, "R1");
      rd_chk(A_MC, 16'h0, "R1");
      rd_chk(A_MODE, 16'h0, "R1");
      rd_chk(A_CNT, 16'h0, "R1");

      // R7: register offsets and mode bit positions
      wr(A_LOC, 16'hA5C3);
      wr(A_MC, 16'h1234);
      wr(A_MODE, 16'hFFFF);
      rd_chk(A_LOC, 16'hA5C3, "R7");
      rd_chk(A_MC, 16'h1234, "R7");
      rd_chk(A_MODE, 16'h0021, "R7");
      wr(A_MODE, 16'h0000);
      rd_chk(A_MODE, 16'h0000, "R7");

      // R6: no pulse while idle
      repeat (2) @(negedge clk);
      chk(!pkt_accept && !pkt_drop, "R6", "idle", int'({pkt_accept, pkt_drop}), 0);

      // R2: unicast, 16-bit, high byte swept
      for (int h = 0; h < 256; h++) send({h[7:0], 8'hC3}, "R2");
      for (int b = 0; b < 16; b++) send(16'hA5C3 ^ (16'h1 << b), "R2");
      // R4: multicast ID ignored when disabled
      send(16'h1234, "R4");
      cnt_chk("R8");

      // R3: multicast enabled
      wr(A_MODE, 16'h0020);
      for (int h = 0; h < 256; h++) send({h[7:0], 8'h34}, "R3");
      for (int h = 0; h < 256; h++) send({h[7:0], 8'hC3}, "R3");
      cnt_chk("R8");

      // R5: 8-bit compare, unicast then multicast
      wr(A_MODE, 16'h0001);
      for (int v = 0; v < 256; v++) send({v[7:0] ^ 8'h5A, v[7:0]}, "R5");
      wr(A_MODE, 16'h0021);
      for (int v = 0; v < 256; v++) send({~v[7:0], v[7:0]}, "R5");
      cnt_chk("R8");

      // R10: write to local ID on the strobe edge, old value judges the packet
      wr(A_MODE, 16'h0000);
      @(negedge clk);
      pkt_start = 1'b1; pkt_dest_id = 16'hA5C3;
      bus_wr = 1'b1; bus_addr = A_LOC; bus_wdata = 16'h0F0F;
      @(negedge clk);
      pkt_start = 1'b0; bus_wr = 1'b0;
      chk(pkt_accept === 1'b1 && pkt_drop === 1'b0, "R10", "old id",
          int'({pkt_accept, pkt_drop}), 2);
      m_loc = 16'h0F0F;
      send(16'h0F0F, "R10");
      send(16'hA5C3, "R10");
      // R10: mode change on the strobe edge
      @(negedge clk);
      pkt_start = 1'b1; pkt_dest_id = 16'h1234;
      bus_wr = 1'b1; bus_addr = A_MODE; bus_wdata = 16'h0020;
      @(negedge clk);
      pkt_start = 1'b0; bus_wr = 1'b0;
      chk(pkt_drop === 1'b1 && pkt_accept === 1'b0, "R10", "old mode",
          int'({pkt_accept, pkt_drop}), 1);
      if (exp_cnt != 16'hFFFF) exp_cnt++;
      m_mcen = 1'b1;
      send(16'h1234, "R10");
      cnt_chk("R8");

      // R9: plain clear, then clear coinciding with a drop
      wr(A_CNT, 16'h0000);
      cnt_chk("R9");
      rd_chk(A_CNT, 16'h0000, "R9");
      send(16'h7777, "R9");
      @(negedge clk);
      pkt_start = 1'b1; pkt_dest_id = 16'h7777;
      bus_wr = 1'b1; bus_addr = A_CNT; bus_wdata = 16'hBEEF;
      @(negedge clk);
      pkt_start = 1'b0; bus_wr = 1'b0;
      exp_cnt = 16'h0001;
      cnt_chk("R9");

      // R8: saturation with back-to-back strobes
      wr(A_CNT, 16'h0000);
      @(negedge clk);
      pkt_start = 1'b1; pkt_dest_id = 16'h7777;
      repeat (65534) @(negedge clk);
      pkt_start = 1'b0;
      exp_cnt = 16'hFFFE;
      cnt_chk("R8");
      send(16'h7777, "R8");
      cnt_chk("R8");
      @(negedge clk);
      pkt_start = 1'b1;
      repeat (4) @(negedge clk);
      pkt_start = 1'b0;
      cnt_chk("R8");
      rd_chk(A_CNT, 16'hFFFF, "R8");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule